// File: doc/BRIEF.md
# Receive squelch data-valid qualifier

This block sits behind the receive slicer of a coaxial line transceiver. It decides whether the sliced receive stream is a genuine signal or noise. Two inputs arrive asynchronously: the sliced binary data and a flag from the analog averaged-level comparator. Both pass through a synchroniser clocked by a sampling clock much faster than the bit rate (100 MHz at the defaults). A run-length filter then removes pulses that are too narrow.

A gap timer is reloaded by every accepted transition. The data-valid flag is high while that timer runs and the level flag is set. While data is valid, the filtered data drives a differential pair without inversion. Otherwise both legs are held low, which is the zero-differential state. The first bit after idle may be lost, because the output gate opens only after the first accepted transition has started the timer.

Top module: `rx_squelch_qual`

## Requirements
- R1: A change of the synchronised input is accepted only after MIN_RUN consecutive samples of the new value (3 samples, over 20 ns, at the defaults). Input pulses of 1 or 2 clock cycles leave the flag and the outputs unchanged.
- R2: `data_valid_o` rises after the first accepted transition while the level flag is set. It stays high without a break while accepted transitions are at most TIMEOUT cycles apart (20 at the defaults). A spacing of TIMEOUT+1 cycles drops it for exactly one cycle.
- R3: While valid, `rx_p_o` equals the filtered data and `rx_n_o` its complement. A high input gives `rx_p_o`=1 and `rx_n_o`=0. The outputs lag the input by MIN_RUN+3 cycles (6 at the defaults).
- R4: After the last input change, `data_valid_o` falls exactly TIMEOUT+MIN_RUN+3 cycles later (26 at the defaults). Whenever the flag was low on the previous cycle, both output legs are 0.
- R5: `data_valid_o` requires the synchronised level flag. Dropping the flag clears validity within the synchroniser delay, even if transitions continue. The level flag with a steady input and no transitions does not assert validity.
- R6: While `rst_ni` is low, `data_valid_o`, `rx_p_o` and `rx_n_o` are 0, and the filtered data is 0.
- R7: A single-cycle glitch inside a data half-bit does not alter the output stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_data_i | input | 1 | Sliced receive data, asynchronous |
| level_ok_i | input | 1 | Averaged-level comparator flag, asynchronous |
| rx_p_o | output | 1 | Differential receive output, plus leg |
| rx_n_o | output | 1 | Differential receive output, minus leg |
| data_valid_o | output | 1 | Combined data-valid qualification |

## Verification
On every cycle, the assertions check the following:
- Each accepted filter change matches the sample that caused it, and accept pulses last a single cycle.
- Every accepted transition starts the gap timer.
- Validity implies the level flag seen through the synchroniser.
- The two output legs differ after a valid cycle and are both low after an invalid one.

The exact widths at which glitches are rejected or accepted need the bench's scenarios. So do the cycle at which validity falls after the last edge, the one-cycle dropout at a gap of TIMEOUT+1, and bit-accurate pass-through of a glitched Manchester burst.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  typedef struct packed {
    logic pos;
    logic neg;
  } diff_t;

  localparam diff_t DIFF_IDLE = '{pos: 1'b0, neg: 1'b0};

  // gated non-inverting differential drive
  function automatic diff_t drive_diff(input logic en, input logic d);
    diff_t r;
    r = en ? '{pos: d, neg: ~d} : DIFF_IDLE;
    return r;
  endfunction

endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/rsq_width_filter.sv
module rsq_width_filter #(
  parameter int unsigned MIN_RUN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sample_i,
  output logic level_o,
  output logic edge_o
);

  localparam int unsigned CW = (MIN_RUN > 2) ? $clog2(MIN_RUN) : 1;
  localparam logic [CW-1:0] RUN_LAST = CW'(MIN_RUN - 1);

  logic [CW-1:0] run_q;
  logic          level_q;
  logic          edge_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= '0;
      level_q <= 1'b0;
      edge_q  <= 1'b0;
    end else if (sample_i != level_q) begin
      if (run_q == RUN_LAST) begin
        level_q <= sample_i;
        edge_q  <= 1'b1;
        run_q   <= '0;
      end else begin
        run_q  <= run_q + 1'b1;
        edge_q <= 1'b0;
      end
    end else begin
      run_q  <= '0;
      edge_q <= 1'b0;
    end
  end

  assign level_o = level_q;
  assign edge_o  = edge_q;

  // R1
  filt_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_q != $past(level_q)) |-> ($past(sample_i) == level_q));

  // R1
  edge_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_q |=> !edge_q);

endmodule

// File: rtl/rsq_gap_timer.sv
module rsq_gap_timer #(
  parameter int unsigned TIMEOUT = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  output logic active_o
);

  localparam int unsigned CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LOAD = CW'(TIMEOUT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (edge_i)         cnt_q <= LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);

  // R2
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_i |=> active_o);

  // R2
  bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LOAD);

endmodule

// File: rtl/rx_squelch_qual.sv
module rx_squelch_qual #(
  parameter int unsigned MIN_RUN     = 3,
  parameter int unsigned TIMEOUT     = 20,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_data_i,
  input  logic level_ok_i,
  output logic rx_p_o,
  output logic rx_n_o,
  output logic data_valid_o
);

  import rsq_pkg::*;

  logic  rx_s, level_s;
  logic  filt, acc_edge, gap_active;
  logic  valid;
  diff_t out_q;

  rsq_sync #(.W(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({level_ok_i, rx_data_i}),
    .q_o    ({level_s, rx_s})
  );

  rsq_width_filter #(.MIN_RUN(MIN_RUN)) i_filter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (rx_s),
    .level_o  (filt),
    .edge_o   (acc_edge)
  );

  rsq_gap_timer #(.TIMEOUT(TIMEOUT)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .edge_i   (acc_edge),
    .active_o (gap_active)
  );

  assign valid = gap_active & level_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= DIFF_IDLE;
    else         out_q <= drive_diff(valid, filt);
  end

  assign rx_p_o       = out_q.pos;
  assign rx_n_o       = out_q.neg;
  assign data_valid_o = valid;

  // R3
  diff_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |=> (rx_p_o != rx_n_o));

  // R4
  zero_diff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_valid_o |=> (!rx_p_o && !rx_n_o));

  // R5
  level_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> $past(level_ok_i, SYNC_STAGES));

  // R3
  legs_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_p_o && rx_n_o));

endmodule

// File: tb/test_rx_squelch_qual.sv
module test_rx_squelch_qual;

  localparam int CLK_P   = 10;
  localparam int LAT     = 6;
  localparam int DROP_AT = 26;

  typedef struct packed {
    logic        rx;
    logic        lvl;
    logic [7:0]  len;
    logic [2:0]  exp;   // {valid, p, n}
  } seg_t;

  localparam seg_t SEGS [16] = '{
    '{1'b0, 1'b1, 8'd30, 3'b000},
    '{1'b1, 1'b1, 8'd1,  3'b000},
    '{1'b0, 1'b1, 8'd30, 3'b000},
    '{1'b1, 1'b1, 8'd2,  3'b000},
    '{1'b0, 1'b1, 8'd30, 3'b000},
    '{1'b1, 1'b1, 8'd3,  3'b000},
    '{1'b0, 1'b1, 8'd8,  3'b101},
    '{1'b0, 1'b1, 8'd40, 3'b000},
    '{1'b1, 1'b1, 8'd8,  3'b110},
    '{1'b0, 1'b1, 8'd8,  3'b101},
    '{1'b1, 1'b0, 8'd8,  3'b000},
    '{1'b0, 1'b0, 8'd8,  3'b000},
    '{1'b1, 1'b1, 8'd30, 3'b000},
    '{1'b1, 1'b1, 8'd10, 3'b000},
    '{1'b0, 1'b1, 8'd8,  3'b101},
    '{1'b0, 1'b1, 8'd40, 3'b000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b0;
  logic lvl = 1'b0;
  logic rx_p, rx_n, dv;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic hist [0:255];
  int   tcnt;

  always #(CLK_P/2) clk = ~clk;

  rx_squelch_qual i_rx_squelch_qual (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .rx_data_i    (rx),
    .level_ok_i   (lvl),
    .rx_p_o       (rx_p),
    .rx_n_o       (rx_n),
    .data_valid_o (dv)
  );

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  function automatic string seg_tag(input int i);
    case (i)
      1, 2, 3, 4: return "R1 narrow pulse rejected";
      5:          return "R1 pulse not yet through";
      6:          return "R1 R2 three-sample pulse accepted";
      7, 15:      return "R4 idle after timeout";
      8:          return "R3 high gives positive differential";
      9, 14:      return "R3 low gives negative differential";
      10, 11:     return "R5 level flag dropped";
      12, 13:     return "R5 level without transitions";
      default:    return "R6 idle after reset";
    endcase
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
  endtask

  // one Manchester cycle: clean value recorded, actual value driven
  task automatic drive_cyc(input logic clean, input logic act, input bit chk_en);
    rx = act;
    hist[tcnt] = clean;
    @(negedge clk);
    tcnt++;
    if (chk_en)
      check("R3 R7 burst pass-through", {dv, rx_p, rx_n},
            {1'b1, hist[tcnt-LAT], ~hist[tcnt-LAT]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] lf;
    logic prev, val, last;
    int drop;
    logic v86, v87;

    // R6 reset state
    repeat (3) @(negedge clk);
    check("R6 reset outputs", {dv, rx_p, rx_n}, 3'b000);
    rst_n = 1'b1;

    for (int i = 0; i < 16; i++) begin
      rx  = SEGS[i].rx;
      lvl = SEGS[i].lvl;
      repeat (int'(SEGS[i].len)) @(negedge clk);
      check(seg_tag(i), {dv, rx_p, rx_n}, SEGS[i].exp);
    end

    // Manchester burst with glitches in transition-free half-bits (R3, R7)
    lf   = 8'hA5;
    prev = rx;
    val  = 1'b0;
    tcnt = 0;
    for (int b = 0; b < 16; b++) begin
      for (int h = 0; h < 2; h++) begin
        val = (h == 0) ? lf[0] : ~lf[0];
        for (int c = 0; c < 5; c++) begin
          drive_cyc(val, (val == prev && c == 2) ? ~val : val, tcnt >= 29);
        end
        prev = val;
      end
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    end
    last = val;

    // R4 exact fall after last change
    rx = ~last;
    repeat (DROP_AT - 1) @(negedge clk);
    check("R4 still valid before timeout", {2'b00, dv}, 3'b001);
    @(negedge clk);
    check("R4 valid falls at timeout", {2'b00, dv}, 3'b000);
    @(negedge clk);
    check("R4 zero differential after timeout", {dv, rx_p, rx_n}, 3'b000);
    repeat (10) @(negedge clk);

    // R2 spacing of TIMEOUT keeps valid, TIMEOUT+1 drops it one cycle
    drop = 0;
    v86 = 1'b0;
    v87 = 1'b0;
    for (int k = 0; k <= 90; k++) begin
      if (k == 0 || k == 20 || k == 40 || k == 60 || k == 81) rx = ~rx;
      @(negedge clk);
      if (k + 1 >= 6 && k + 1 <= 85 && dv !== 1'b1) drop++;
      if (k + 1 == 86) v86 = dv;
      if (k + 1 == 87) v87 = dv;
    end
    check("R2 no dropout at max spacing", 3'(drop), 3'd0);
    check("R2 dropout at spacing plus one", {2'b00, v86}, 3'b000);
    check("R2 revalid after late edge", {2'b00, v87}, 3'b001);

    // R6 asynchronous reset while valid
    rst_n = 1'b0;
    #1;
    check("R6 async reset clears", {dv, rx_p, rx_n}, 3'b000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R6 idle after reset release", {dv, rx_p, rx_n}, 3'b000);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule